// File: doc/BRIEF.md
# Rotated Immediate Codec

This unit converts between the 12-bit immediate field of a 32-bit fixed-length instruction word and the 32-bit constant that the field stands for. The field does not hold a plain number. Its low 8 bits are a payload, and its upper 4 bits give a rotation count. The constant is the zero-extended payload rotated right by twice that count. The decode path expands a field into its constant. The encode path takes any 32-bit constant, reports whether some field can express it, and, if one can, returns a single canonical field.

The encoder tries all sixteen rotations. Many constants can be reached by more than one rotation, so the encoder always returns the one with the smallest rotation count. This makes a decode followed by an encode repeatable. A small extractor sits beside the codec. It splits a data-processing instruction word into its condition, destination register, immediate-select flag and immediate field, and it flags whether the word belongs to the data-processing class.

By default all outputs pass through one register stage with a synchronous active-high reset. Setting `REG_OUT` to 0 makes the unit purely combinational.

Top module: `rot_imm_codec`

## Requirements
- R1: `dec_value` equals `dec_field[7:0]`, zero-extended to 32 bits and rotated right by 2×`dec_field[11:8]` bit positions. It therefore never has more than 8 bits set.
- R2: Across all 4096 values of `dec_field`, exactly 3073 distinct `dec_value` results appear.
- R3: `enc_ok` is 1 exactly when some r in 0..15 exists such that `enc_value` rotated left by 2r has bits 31:8 all zero.
- R4: When `enc_ok` is 1, `enc_field[11:8]` holds the smallest such r and `enc_field[7:0]` holds bits 7:0 of `enc_value` rotated left by 2r. Decoding `enc_field` then gives back `enc_value`. Whenever r is nonzero, `enc_field[1:0]` is nonzero.
- R5: When `enc_ok` is 0, `enc_field` is zero.
- R6: The extractor outputs are taken from `insn` as follows: `insn_cond` from bits 31:28, `insn_isel` from bit 25, `insn_rd` from bits 15:12 and `insn_imm` from bits 11:0. `insn_dp` is 1 exactly when bits 27:26 are both zero.
- R7: With `REG_OUT`=1, every output reflects the inputs from the previous rising clock edge. A rising edge with `rst` high sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| dec_field | input | 12 | Immediate field to expand |
| dec_value | output | 32 | Constant encoded by `dec_field` |
| enc_value | input | 32 | Constant to encode |
| enc_ok | output | 1 | `enc_value` can be expressed as a field |
| enc_field | output | 12 | Canonical field for `enc_value`, zero if none |
| insn | input | 32 | Data-processing instruction word |
| insn_cond | output | 4 | Condition code of `insn` |
| insn_rd | output | 4 | Destination register number of `insn` |
| insn_imm | output | 12 | Immediate field of `insn` |
| insn_isel | output | 1 | Immediate-select flag of `insn` |
| insn_dp | output | 1 | `insn` has the data-processing class bits cleared |

## Verification
The hardest behaviour to reach is the choice of one canonical field among several equivalent ones. Those duplicates only appear for payloads whose low bits are zero, combined with particular rotations. Random constants almost never land on them. To reach them, the stimulus sweeps every one of the 4096 field codes through the decoder. In the same cycle it feeds the constant that the bench expects from each code into the encoder. Every duplicate constant is therefore presented, and the smallest-rotation rule is tested on each one. The distinct decoded results are also collected, so the count of 3073 can be confirmed.

// File: rtl/rot_imm_codec.sv
module rot_imm_codec #(
  parameter int DATA_W  = 32,
  parameter int PAY_W   = 8,
  parameter int ROT_W   = 4,
  parameter int REG_OUT = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PAY_W+ROT_W-1:0] dec_field,
  output logic [DATA_W-1:0]      dec_value,
  input  logic [DATA_W-1:0]      enc_value,
  output logic                   enc_ok,
  output logic [PAY_W+ROT_W-1:0] enc_field,
  input  logic [DATA_W-1:0]      insn,
  output logic [3:0]             insn_cond,
  output logic [3:0]             insn_rd,
  output logic [PAY_W+ROT_W-1:0] insn_imm,
  output logic                   insn_isel,
  output logic                   insn_dp
);
  localparam int FLD_W  = PAY_W + ROT_W;
  localparam int NROT   = 1 << ROT_W;
  localparam int COND_L = DATA_W - 4;
  localparam int CLS_L  = DATA_W - 6;
  localparam int ISEL_B = DATA_W - 7;
  localparam int RD_L   = FLD_W;
  localparam int BUS_W  = DATA_W + 1 + FLD_W + 4 + 4 + FLD_W + 1 + 1;

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] x, input int unsigned s);
    logic [2*DATA_W-1:0] t;
    t = {x, x} << (s % DATA_W);
    return t[2*DATA_W-1:DATA_W];
  endfunction

  logic [2*DATA_W-1:0] d_dbl;
  logic [DATA_W-1:0]   d_val, d_pay;
  assign d_pay = DATA_W'(dec_field[PAY_W-1:0]);
  assign d_dbl = {d_pay, d_pay} >> ({dec_field[FLD_W-1:PAY_W], 1'b0} % DATA_W);
  assign d_val = d_dbl[DATA_W-1:0];

  logic             c_ok;
  logic [ROT_W-1:0] c_rot;
  logic [PAY_W-1:0] c_pay;
  logic [DATA_W-1:0] c_rl;

  always_comb begin
    c_ok  = 1'b0;
    c_rot = '0;
    c_pay = '0;
    c_rl  = '0;
    for (int r = NROT - 1; r >= 0; r--) begin
      c_rl = rotl(enc_value, 2 * r);
      if (c_rl[DATA_W-1:PAY_W] == '0) begin
        c_ok  = 1'b1;
        c_rot = r[ROT_W-1:0];
        c_pay = c_rl[PAY_W-1:0];
      end
    end
  end

  logic [BUS_W-1:0] nxt, cur;
  assign nxt = {d_val, c_ok, c_rot, c_pay,
                insn[COND_L+:4], insn[RD_L+:4], insn[FLD_W-1:0],
                insn[ISEL_B], insn[CLS_L+:2] == 2'b00};

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
      end
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign {dec_value, enc_ok, enc_field, insn_cond, insn_rd, insn_imm, insn_isel, insn_dp} = cur;
endmodule

module rot_imm_codec_chk #(
  parameter int DATA_W  = 32,
  parameter int PAY_W   = 8,
  parameter int ROT_W   = 4,
  parameter int REG_OUT = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [PAY_W+ROT_W-1:0] dec_field,
  input logic [DATA_W-1:0]      dec_value,
  input logic [DATA_W-1:0]      enc_value,
  input logic                   enc_ok,
  input logic [PAY_W+ROT_W-1:0] enc_field,
  input logic [DATA_W-1:0]      insn,
  input logic [3:0]             insn_cond,
  input logic [3:0]             insn_rd,
  input logic [PAY_W+ROT_W-1:0] insn_imm,
  input logic                   insn_isel,
  input logic                   insn_dp
);
  localparam int FLD_W = PAY_W + ROT_W;

  a_r5_reject_zero: assert property (@(posedge clk) disable iff (rst)
    !enc_ok |-> enc_field == '0);

  a_r4_canonical: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && enc_field[FLD_W-1:PAY_W] != '0) |-> enc_field[1:0] != 2'b00);

  a_r1_sparse: assert property (@(posedge clk) disable iff (rst)
    $countones(dec_value) <= PAY_W);

  generate
    if (REG_OUT != 0) begin : g_seq
      a_r1_zero_payload: assert property (@(posedge clk) disable iff (rst)
        $past(dec_field[PAY_W-1:0]) == '0 |-> dec_value == '0);

      a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dec_value == '0 && !enc_ok && enc_field == '0 &&
                        insn_cond == '0 && insn_imm == '0 && !insn_dp));

      a_r6_cond_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (insn_cond == $past(insn[DATA_W-1 -: 4]) &&
                         insn_rd == $past(insn[FLD_W +: 4])));
    end
  endgenerate
endmodule

bind rot_imm_codec rot_imm_codec_chk #(
  .DATA_W(DATA_W), .PAY_W(PAY_W), .ROT_W(ROT_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_rot_imm_codec.sv
`timescale 1ns/1ps
module sim_rot_imm_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] dec_field = '0;
  logic [31:0] enc_value = '0;
  logic [31:0] insn = '0;
  logic [31:0] dec_value;
  logic        enc_ok;
  logic [11:0] enc_field;
  logic [3:0]  insn_cond, insn_rd;
  logic [11:0] insn_imm;
  logic        insn_isel, insn_dp;

  always #2 clk = ~clk;

  rot_imm_codec u0 (
    .clk(clk), .rst(rst),
    .dec_field(dec_field), .dec_value(dec_value),
    .enc_value(enc_value), .enc_ok(enc_ok), .enc_field(enc_field),
    .insn(insn), .insn_cond(insn_cond), .insn_rd(insn_rd),
    .insn_imm(insn_imm), .insn_isel(insn_isel), .insn_dp(insn_dp)
  );

  typedef struct {
    logic [31:0] dv;
    logic        ok;
    logic [11:0] ef;
    logic [3:0]  cond, rd;
    logic [11:0] imm;
    logic        isel, dp;
    bit          sweep;
  } item_t;

  item_t q[$];
  item_t it;
  bit seen [bit [31:0]];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] m_rotr(logic [31:0] v, int s);
    if (s == 0) return v;
    return (v >> s) | (v << (32 - s));
  endfunction

  function automatic logic [31:0] m_dec(logic [11:0] f);
    return m_rotr({24'h0, f[7:0]}, 2 * f[11:8]);
  endfunction

  function automatic void m_enc(logic [31:0] v, output logic ok, output logic [11:0] f);
    ok = 0; f = '0;
    for (int r = 0; r < 16; r++) begin
      logic [31:0] t;
      t = m_rotr(v, (32 - 2 * r) % 32);
      if (!ok && t < 32'd256) begin
        ok = 1; f = {r[3:0], t[7:0]};
      end
    end
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] f, logic [31:0] v, logic [31:0] w, bit sw);
    item_t e;
    @(negedge clk);
    dec_field = f; enc_value = v; insn = w;
    e.dv = m_dec(f);
    m_enc(v, e.ok, e.ef);
    e.cond = w[31:28]; e.rd = w[15:12]; e.imm = w[11:0];
    e.isel = w[25]; e.dp = (w[27:26] == 2'b00);
    e.sweep = sw;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk("R1 dec_value", dec_value, it.dv);
      chk("R3 enc_ok", {31'b0, enc_ok}, {31'b0, it.ok});
      chk(it.ok ? "R4 enc_field" : "R5 enc_field", {20'b0, enc_field}, {20'b0, it.ef});
      chk("R6 cond", {28'b0, insn_cond}, {28'b0, it.cond});
      chk("R6 rd", {28'b0, insn_rd}, {28'b0, it.rd});
      chk("R6 imm", {20'b0, insn_imm}, {20'b0, it.imm});
      chk("R6 isel", {31'b0, insn_isel}, {31'b0, it.isel});
      chk("R6 dp", {31'b0, insn_dp}, {31'b0, it.dp});
      if (it.sweep) seen[dec_value] = 1'b1;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R7 reset dec_value", dec_value, 32'h0);
    chk("R7 reset enc_ok", {31'b0, enc_ok}, 32'h0);
    rst = 1'b0;

    for (int c = 0; c < 4096; c++)
      drive(c[11:0], m_dec(c[11:0]), $urandom, 1'b1);

    drive(12'h000, 32'h0000_0000, 32'h0000_0000, 0);
    drive(12'h0FF, 32'h0000_00FF, 32'hE3A0_1C01, 0);
    drive(12'hC01, 32'h0000_0100, 32'hF3FF_FFFF, 0);
    drive(12'h2FF, 32'hF000_000F, 32'h0C00_0000, 0);
    drive(12'h4FF, 32'hFF00_0000, 32'h0400_0000, 0);
    drive(12'h1FF, 32'h0000_0101, 32'h0800_0000, 0);
    drive(12'hFFF, 32'hFFFF_FFFF, 32'h0200_0000, 0);
    drive(12'h801, 32'h0000_0FF0, 32'h1234_5678, 0);

    for (int i = 0; i < 600; i++)
      drive($urandom, $urandom, $urandom, 0);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] p;
      p = m_rotr({24'h0, 8'($urandom)}, $urandom_range(0, 31));
      drive($urandom, p, $urandom, 0);
    end

    repeat (3) @(negedge clk);
    chk("R2 distinct decoded values", seen.num(), 32'd3073);

    dec_field = 12'h0AB; enc_value = 32'h0000_00AB; insn = 32'hFFFF_FFFF;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R7 reset clears dec_value", dec_value, 32'h0);
    chk("R7 reset clears enc_field", {20'b0, enc_field}, 32'h0);
    chk("R7 reset clears insn_cond", {28'b0, insn_cond}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    dec_field = 12'h0FF;
    #1;
    chk("R7 no change before edge", dec_value, 32'h0);
    @(posedge clk); #1;
    chk("R7 one cycle latency", dec_value, 32'h0000_00FF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule